// File: doc/BRIEF.md
# System Clock Source Selector with Internal Divider

This block decides which oscillator drives the system clock and produces a one-cycle clock enable, `sys_ce`, that the CPU and peripheral clocking use as their time base. Both oscillators appear as enable pulses sampled on a fast reference clock. `hs_tick` is the internal high-speed oscillator and `xt_tick` is the external main oscillator. After reset the block always runs from the internal oscillator. A 4-bit boot configuration value, held on `boot_cfg` while reset is asserted, selects the internal base frequency (32 MHz or 24 MHz) and the initial divide ratio.

Software uses a small write port with four registers:

- **Mode register (address 0):** write-once. Bit 0 enables use of the external oscillator pins.
- **Oscillator control (address 1):** bit 0 runs the external oscillator and bit 1 requests the switch to it.
- **Divider select (address 2):** bits 2:0 hold the divider code.
- **Stabilisation prescale (address 3):** bits 1:0 select the prescale.

While the external oscillator runs, an 8-bit stabilisation counter advances and then saturates. A switch request is accepted only once that counter is saturated. The switch itself passes through a hold state with the enable forced low. `src_ext` reports which source is actually driving the output.

The source controller is a four-state machine:

- **ST_INT:** running from the internal oscillator.
  - ST_INT → ST_TO_EXT when the request bit is set.
- **ST_TO_EXT:** held low, waiting for an edge of the external oscillator.
  - ST_TO_EXT → ST_EXT on the first `xt_tick`.
- **ST_EXT:** running from the external oscillator.
  - ST_EXT → ST_TO_INT when the request bit is cleared.
- **ST_TO_INT:** held low, waiting for an edge of the internal oscillator.
  - ST_TO_INT → ST_INT on the first `hs_tick`.

Top module: `clksel_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the source is internal: `src_ext`=0, `sys_ce`=0, `xosc_on`=0, `req_q`=0, `stab_cnt`=0, `mode_q`=0.
- R2: At reset, `base_hi` takes `boot_cfg[3]` (1 = 32 MHz base, 0 = 24 MHz base). `div_code` takes `boot_cfg[2:0]` if that code is legal for the base. An illegal code gives the slowest legal code instead: 5 for the 32 MHz base, 3 for the 24 MHz base.
- R3: The legal codes are 0..5 with the 32 MHz base and 0..3 with the 24 MHz base. Code c divides by 2^c. In ST_INT, `sys_ce` is high for one cycle on every 2^c-th `hs_tick` counted from a divider restart, and it appears one clock after that tick.
- R4: A write of a legal code to address 2 replaces `div_code` and restarts the divider count. A write of an illegal code leaves both `div_code` and the output timing unchanged.
- R5: The first write to address 0 after reset sets `mode_q`. Every later write to address 0 is ignored.
- R6: A write to address 1 sets the run bit (bit 0) only if `mode_q[0]`=1. Clearing the run bit is ignored while `req_q`=1 or the state is not ST_INT.
- R7: While the run bit is set, `stab_cnt` advances once per 2^s `xt_tick` pulses, where s is address 3 bits 1:0. It saturates at 0xFF. It reads 0 one cycle after the run bit clears.
- R8: Writing bit 1 of address 1 as 1 sets `req_q` only if the external oscillator runs and `stab_cnt` is 0xFF. Otherwise the request is dropped and the source and `src_ext` are unchanged. Writing bit 1 as 0 always clears `req_q`.
- R9: After the request is set, the next clock enters ST_TO_EXT. The first `xt_tick` then enters ST_EXT and sets `src_ext`, with `sys_ce` low through the hold state and on that edge. In ST_EXT, `sys_ce` follows `xt_tick` one clock later.
- R10: After the request is cleared, the next clock enters ST_TO_INT, where `sys_ce` is low and `src_ext` is still 1. The first `hs_tick` enters ST_INT, clears `src_ext` and restarts the divider, so R3 timing applies from the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_tick | input | 1 | Internal high-speed oscillator edge enable |
| xt_tick | input | 1 | External main oscillator edge enable |
| boot_cfg | input | 4 | Boot configuration: bit 3 base select, bits 2:0 divider code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| sys_ce | output | 1 | Divided system clock enable |
| src_ext | output | 1 | 1 when the external oscillator drives `sys_ce` |
| base_hi | output | 1 | 1 for the 32 MHz base, 0 for the 24 MHz base |
| div_code | output | 3 | Current divider code |
| mode_q | output | 8 | Mode register contents |
| xosc_on | output | 1 | External oscillator run bit |
| req_q | output | 1 | External source request bit |
| stab_cnt | output | 8 | Stabilisation counter |

## Verification
A wrong divider count shows up at `sys_ce` within one divide period, at most 32 internal ticks, as a pulse in the wrong cycle. A wrong state in the source machine shows up within one or two clocks of the request write, as a pulse during the hold window or a `src_ext` change one edge early or late. Write-once and gating faults are visible on the register outputs on the clock after the offending write. A stuck or non-saturating stabilisation counter shows up in `stab_cnt` after 255 or more external ticks.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        ST_INT    = 2'd0,
        ST_TO_EXT = 2'd1,
        ST_EXT    = 2'd2,
        ST_TO_INT = 2'd3
    } src_state_t;

    localparam int          ADDR_W    = 2;
    localparam logic [1:0]  A_MODE    = 2'd0;
    localparam logic [1:0]  A_OSC     = 2'd1;
    localparam logic [1:0]  A_DIV     = 2'd2;
    localparam logic [1:0]  A_STAB    = 2'd3;
    localparam logic [2:0]  MAX_HI    = 3'd5;
    localparam logic [2:0]  MAX_LO    = 3'd3;

    function automatic logic code_ok(input logic base_hi, input logic [2:0] code);
        return base_hi ? (code <= MAX_HI) : (code <= MAX_LO);
    endfunction

    function automatic logic [2:0] slowest(input logic base_hi);
        return base_hi ? MAX_HI : MAX_LO;
    endfunction

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        boot_cfg,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              stab_full,
    input  logic              busy,
    output logic              base_hi,
    output logic [2:0]        div_code,
    output logic              div_load,
    output logic [7:0]        mode_q,
    output logic              xosc_on,
    output logic              req_q,
    output logic [SEL_W-1:0]  stab_sel
);

    logic mode_locked;

    assign div_load = wr_en && (wr_addr == A_DIV) && code_ok(base_hi, wr_data[2:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi     <= boot_cfg[3];
            div_code    <= code_ok(boot_cfg[3], boot_cfg[2:0]) ? boot_cfg[2:0]
                                                               : slowest(boot_cfg[3]);
            mode_q      <= '0;
            mode_locked <= 1'b0;
            xosc_on     <= 1'b0;
            req_q       <= 1'b0;
            stab_sel    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_MODE: begin
                    if (!mode_locked) begin
                        mode_q      <= wr_data;
                        mode_locked <= 1'b1;
                    end
                end
                A_OSC: begin
                    if (wr_data[0]) begin
                        if (mode_q[0]) xosc_on <= 1'b1;
                    end else if (!req_q && !busy) begin
                        xosc_on <= 1'b0;
                    end
                    if (wr_data[1]) begin
                        if (stab_full && xosc_on) req_q <= 1'b1;
                    end else begin
                        req_q <= 1'b0;
                    end
                end
                A_DIV: begin
                    if (div_load) div_code <= wr_data[2:0];
                end
                A_STAB: stab_sel <= wr_data[SEL_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/clksel_stab.sv
module clksel_stab #(
    parameter int STAB_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              xt_tick,
    input  logic [SEL_W-1:0]  sel,
    output logic [STAB_W-1:0] cnt,
    output logic              full
);

    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;

    assign lim  = ~({PRE_W{1'b1}} << sel);
    assign full = &cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (!run) begin
            pre <= '0;
            cnt <= '0;
        end else if (xt_tick) begin
            if (pre == lim) begin
                pre <= '0;
                if (!full) cnt <= cnt + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clksel_div.sv
module clksel_div #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clr,
    input  logic [2:0] code,
    output logic       ce
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    assign mask = ~({CNT_W{1'b1}} << code);
    assign ce   = tick && !clr && ((cnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int STAB_W = 8,
    parameter int SEL_W  = 2,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_tick,
    input  logic              xt_tick,
    input  logic [3:0]        boot_cfg,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic              sys_ce,
    output logic              src_ext,
    output logic              base_hi,
    output logic [2:0]        div_code,
    output logic [7:0]        mode_q,
    output logic              xosc_on,
    output logic              req_q,
    output logic [STAB_W-1:0] stab_cnt
);

    src_state_t       state_q, state_d;
    logic             div_load, stab_full, int_ce, busy;
    logic [SEL_W-1:0] stab_sel;

    assign busy    = (state_q != ST_INT);
    assign src_ext = (state_q == ST_EXT) || (state_q == ST_TO_INT);

    clksel_regs #(.SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .boot_cfg(boot_cfg),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stab_full(stab_full), .busy(busy),
        .base_hi(base_hi), .div_code(div_code), .div_load(div_load),
        .mode_q(mode_q), .xosc_on(xosc_on), .req_q(req_q), .stab_sel(stab_sel)
    );

    clksel_stab #(.STAB_W(STAB_W), .SEL_W(SEL_W)) stab_i (
        .clk(clk), .rst_n(rst_n), .run(xosc_on), .xt_tick(xt_tick),
        .sel(stab_sel), .cnt(stab_cnt), .full(stab_full)
    );

    clksel_div #(.CNT_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .tick(hs_tick),
        .clr(div_load || busy), .code(div_code), .ce(int_ce)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INT:    if (req_q)    state_d = ST_TO_EXT;
            ST_TO_EXT: if (xt_tick)  state_d = ST_EXT;
            ST_EXT:    if (!req_q)   state_d = ST_TO_INT;
            ST_TO_INT: if (hs_tick)  state_d = ST_INT;
            default:                 state_d = ST_INT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_ce <= 1'b0;
        end else begin
            unique case (state_q)
                ST_INT:  sys_ce <= int_ce;
                ST_EXT:  sys_ce <= xt_tick;
                default: sys_ce <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk #(
    parameter int STAB_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              sys_ce,
    input logic              src_ext,
    input logic              base_hi,
    input logic [2:0]        div_code,
    input logic [7:0]        mode_q,
    input logic              xosc_on,
    input logic              req_q,
    input logic [STAB_W-1:0] stab_cnt
);

    logic mode_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mode_seen <= 1'b0;
        else if (wr_en && wr_addr == 2'd0)   mode_seen <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_internal_R1: assert (!src_ext && !sys_ce && !xosc_on && !req_q);
        end
    end

    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base_hi ? (div_code <= 3'd5) : (div_code <= 3'd3));

    assert_mode_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_seen |=> $stable(mode_q));

    assert_stab_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xosc_on && (&stab_cnt)) |=> (&stab_cnt));

    assert_req_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(&stab_cnt));

    assert_switch_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ext) |-> (&stab_cnt));

    assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(src_ext) || $fell(src_ext)) |-> !sys_ce);

endmodule

bind clksel_ctrl clksel_ctrl_chk #(.STAB_W(STAB_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .sys_ce(sys_ce), .src_ext(src_ext), .base_hi(base_hi), .div_code(div_code),
    .mode_q(mode_q), .xosc_on(xosc_on), .req_q(req_q), .stab_cnt(stab_cnt)
);

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_tick = 1'b0;
    logic       xt_tick = 1'b0;
    logic [3:0] boot_cfg = 4'h0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       sys_ce, src_ext, base_hi, xosc_on, req_q;
    logic [2:0] div_code;
    logic [7:0] mode_q, stab_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clksel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .hs_tick(hs_tick), .xt_tick(xt_tick),
        .boot_cfg(boot_cfg), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sys_ce(sys_ce), .src_ext(src_ext), .base_hi(base_hi), .div_code(div_code),
        .mode_q(mode_q), .xosc_on(xosc_on), .req_q(req_q), .stab_cnt(stab_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] cfg);
        @(negedge clk);
        rst_n    = 1'b0;
        boot_cfg = cfg;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // 64 back-to-back internal ticks; pulse expected after tick j when (j+1) % div == 0
    task automatic run_period(input int div, input string tag);
        int errs;
        errs = 0;
        hs_tick = 1'b1;
        for (int j = 0; j < 64; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (sys_ce !== (((j + 1) % div) == 0)) errs++;
        end
        hs_tick = 1'b0;
        check(tag, errs, 0);
    endtask

    task automatic xt_pulses(input int n);
        xt_tick = 1'b1;
        idle(n);
        xt_tick = 1'b0;
    endtask

    function automatic int exp_code(input int hi, input int c);
        int mx;
        mx = hi ? 5 : 3;
        return (c <= mx) ? c : mx;
    endfunction

    task automatic main_seq();
        int cur;
        // R1: reset values, checked during reset
        @(negedge clk);
        check("R1 src_ext in reset", src_ext, 0);
        check("R1 sys_ce in reset", sys_ce, 0);

        // R2/R3: every boot configuration
        for (int hi = 0; hi < 2; hi++) begin
            for (int c = 0; c < 8; c++) begin
                do_reset(4'(hi * 8 + c));
                check("R1 src_ext", src_ext, 0);
                check("R1 xosc/req/stab/mode", int'(xosc_on) + int'(req_q) + int'(stab_cnt) + int'(mode_q), 0);
                check("R2 base_hi", base_hi, hi);
                check("R2 div_code", div_code, exp_code(hi, c));
                run_period(1 << exp_code(hi, c), "R3 divide period");
            end
        end

        // R4: divider writes, legal and illegal, for both bases
        for (int hi = 0; hi < 2; hi++) begin
            do_reset(4'(hi * 8));
            cur = 0;
            for (int c = 7; c >= 0; c--) begin
                wr(2'd2, 8'(c));
                if (c <= (hi ? 5 : 3)) cur = c;
                check("R4 div_code after write", div_code, cur);
                run_period(1 << cur, "R4 period after write");
            end
        end

        // External source path, 32 MHz base, divide by 2
        do_reset(4'h9);
        wr(2'd1, 8'h01);
        check("R6 run ignored without mode", xosc_on, 0);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        check("R5 second mode write ignored", mode_q, 1);
        wr(2'd1, 8'h01);
        check("R6 run accepted", xosc_on, 1);
        wr(2'd1, 8'h03);
        check("R8 early request dropped", req_q, 0);
        xt_pulses(254);
        check("R7 count 254", stab_cnt, 254);
        wr(2'd1, 8'h03);
        check("R8 request at 254 dropped", req_q, 0);
        idle(2);
        check("R8 source unchanged", src_ext, 0);
        xt_pulses(1);
        check("R7 count 255", stab_cnt, 255);
        xt_pulses(20);
        check("R7 saturates", stab_cnt, 255);

        wr(2'd1, 8'h03);
        check("R8 request accepted", req_q, 1);
        xt_tick = 1'b1;
        idle(1);
        check("R9 hold: src_ext", src_ext, 0);
        check("R9 hold: sys_ce", sys_ce, 0);
        idle(1);
        check("R9 switched: src_ext", src_ext, 1);
        check("R9 switch edge: sys_ce", sys_ce, 0);
        idle(1);
        check("R9 follows xt high", sys_ce, 1);
        xt_tick = 1'b0;
        idle(1);
        check("R9 follows xt low", sys_ce, 0);

        wr(2'd1, 8'h02);
        check("R6 stop ignored with request", xosc_on, 1);
        wr(2'd1, 8'h00);
        check("R8 request cleared", req_q, 0);
        check("R6 stop ignored while external", xosc_on, 1);
        idle(1);
        check("R10 hold: src_ext", src_ext, 1);
        check("R10 hold: sys_ce", sys_ce, 0);
        hs_tick = 1'b1;
        idle(1);
        check("R10 back internal: src_ext", src_ext, 0);
        check("R10 back internal: sys_ce", sys_ce, 0);
        run_period(2, "R10 divider restarted");

        wr(2'd1, 8'h00);
        check("R6 stop accepted", xosc_on, 0);
        idle(1);
        check("R7 cleared on stop", stab_cnt, 0);
        wr(2'd3, 8'h02);
        wr(2'd1, 8'h01);
        xt_pulses(12);
        check("R7 prescale by 4", stab_cnt, 3);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule